// File: doc/BRIEF.md
# Dual-Mode Program Counter Unit

This block keeps the program counter of an 8-bit-accumulator style processor and works out where the next instruction fetch starts. Each clock edge, unless stalled, it adds the current instruction's byte length to the PC. If a jump is taken, it loads a jump target instead. The caller supplies the instruction length, a two-bit jump kind, a taken flag and the raw operand bits. Opcode decode, condition evaluation, the return stack and memory access are all handled outside the block.

A runtime mode input selects the address width. In wide mode the PC holds 24 bits and reaches a 16 MB program space. In narrow mode only 16 bits are live and bits 23:16 stay zero. The mode also sets the size of the page that short absolute targets stay inside: 512 KB in wide mode and 2 KB in narrow mode. That page is always the page of the byte that follows the jump instruction.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` becomes 0 at that edge.
- R2: While `stall` is high (and `rst` low), `pc` keeps its value regardless of every other input.
- R3: With `jump_kind` = 2'b00 (none), or with `taken` low for any kind, `pc` advances by `instr_len` (1 to 5) at the next edge.
- R4: With `jump_kind` = 2'b01 (long absolute), `taken` high and `flat_mode` high, `pc` becomes `operand[23:0]`.
- R5: With `jump_kind` = 2'b01, `taken` high and `flat_mode` low, `pc` becomes `operand[15:0]` with bits 23:16 zero.
- R6: With `jump_kind` = 2'b10 (page absolute), `taken` high and `flat_mode` high, `pc[18:0]` becomes `operand[18:0]` and `pc[23:19]` is taken from the following-instruction address.
- R7: With `jump_kind` = 2'b10, `taken` high and `flat_mode` low, `pc[10:0]` becomes `operand[10:0]`, `pc[15:11]` is taken from the following-instruction address, and bits 23:16 are zero.
- R8: The page kept by a page-absolute jump is the page of `pc + instr_len`, not the page of `pc`, so a jump whose last byte ends a page lands in the next page.
- R9: With `jump_kind` = 2'b11 (relative) and `taken` high, `pc` becomes `pc + instr_len + sext(operand[7:0])`, where `operand[7:0]` is two's complement in the range -128..+127.
- R10: In narrow mode all PC arithmetic wraps modulo 2^16 and `pc[23:16]` is zero after every non-stalled edge. In wide mode arithmetic wraps modulo 2^24.
- R11: Every update takes effect at the first rising edge after the inputs are presented, with no extra latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold the PC this cycle |
| flat_mode | input | 1 | 1: 24-bit addressing, 0: 16-bit addressing |
| instr_len | input | 3 | Byte length of the current instruction, 1 to 5 |
| jump_kind | input | 2 | 00 none, 01 long absolute, 10 page absolute, 11 relative |
| taken | input | 1 | Jump or branch is taken |
| operand | input | 24 | Raw target bits or offset from the instruction stream |
| pc | output | 24 | Registered program counter |

## Verification
The bench uses the default parameters: a 24-bit PC, a 16-bit narrow width, page fields of 19 and 11 bits, and an 8-bit offset. With these widths, short sequences can place the PC one byte before a 2 KB or 512 KB boundary. They can also place it just below the top of both address spaces. Page crossings, wrap-around in either mode and the extreme offsets -128 and +127 are therefore reached directly. A long stream of randomly generated instructions, including mode switches, follows the directed cases.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    localparam int PC_WIDTH    = 24;
    localparam int NARROW_W    = 16;
    localparam int WIDE_PAGE   = 19;
    localparam int NARROW_PAGE = 11;
    localparam int OFFSET_W    = 8;
    localparam int LEN_W       = 3;

    typedef enum logic [1:0] {
        JK_NONE = 2'b00,
        JK_LONG = 2'b01,
        JK_PAGE = 2'b10,
        JK_REL  = 2'b11
    } jump_kind_e;

endpackage

// File: rtl/pc_seq_add.sv
module pc_seq_add #(
    parameter int PC_W  = 24,
    parameter int NAR_W = 16,
    parameter int LEN_W = 3
) (
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [LEN_W-1:0] len,
    input  logic             wide,
    output logic [PC_W-1:0]  seq_pc
);
    localparam logic [PC_W-1:0] NAR_MASK = PC_W'((64'd1 << NAR_W) - 64'd1);

    logic [PC_W-1:0] sum;

    always_comb begin
        sum    = cur_pc + PC_W'(len);
        seq_pc = wide ? sum : (sum & NAR_MASK);
    end
endmodule

// File: rtl/pc_rel_add.sv
module pc_rel_add #(
    parameter int PC_W  = 24,
    parameter int NAR_W = 16,
    parameter int OFS_W = 8
) (
    input  logic [PC_W-1:0]  base_pc,
    input  logic [OFS_W-1:0] offset,
    input  logic             wide,
    output logic [PC_W-1:0]  rel_pc
);
    localparam logic [PC_W-1:0] NAR_MASK = PC_W'((64'd1 << NAR_W) - 64'd1);

    logic [PC_W-1:0] ext_ofs;
    logic [PC_W-1:0] sum;

    always_comb begin
        ext_ofs = {{(PC_W-OFS_W){offset[OFS_W-1]}}, offset};
        sum     = base_pc + ext_ofs;
        rel_pc  = wide ? sum : (sum & NAR_MASK);
    end
endmodule

// File: rtl/pc_abs_form.sv
module pc_abs_form #(
    parameter int PC_W   = 24,
    parameter int NAR_W  = 16,
    parameter int WPAGE  = 19,
    parameter int NPAGE  = 11
) (
    input  logic [PC_W-1:0] base_pc,
    input  logic [PC_W-1:0] field,
    input  logic            wide,
    output logic [PC_W-1:0] long_pc,
    output logic [PC_W-1:0] page_pc
);
    localparam logic [PC_W-1:0] NAR_MASK   = PC_W'((64'd1 << NAR_W) - 64'd1);
    localparam logic [PC_W-1:0] WPAGE_LOW  = PC_W'((64'd1 << WPAGE) - 64'd1);
    localparam logic [PC_W-1:0] NPAGE_LOW  = PC_W'((64'd1 << NPAGE) - 64'd1);

    logic [PC_W-1:0] low_mask;
    logic [PC_W-1:0] keep_mask;

    always_comb begin
        low_mask  = wide ? WPAGE_LOW : NPAGE_LOW;
        keep_mask = wide ? ~WPAGE_LOW : (NAR_MASK & ~NPAGE_LOW);
        long_pc   = wide ? field : (field & NAR_MASK);
        page_pc   = (base_pc & keep_mask) | (field & low_mask);
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pc_seq_pkg::*;
#(
    parameter int PC_W  = PC_WIDTH,
    parameter int NAR_W = NARROW_W,
    parameter int WPAGE = WIDE_PAGE,
    parameter int NPAGE = NARROW_PAGE,
    parameter int OFS_W = OFFSET_W,
    parameter int LW    = LEN_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall,
    input  logic            flat_mode,
    input  logic [LW-1:0]   instr_len,
    input  logic [1:0]      jump_kind,
    input  logic            taken,
    input  logic [PC_W-1:0] operand,
    output logic [PC_W-1:0] pc
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] rel_pc;
    logic [PC_W-1:0] long_pc;
    logic [PC_W-1:0] page_pc;
    jump_kind_e      kind;

    assign kind = jump_kind_e'(jump_kind);

    pc_seq_add #(.PC_W(PC_W), .NAR_W(NAR_W), .LEN_W(LW)) u_seq (
        .cur_pc (state_q.pc),
        .len    (instr_len),
        .wide   (flat_mode),
        .seq_pc (seq_pc)
    );

    pc_rel_add #(.PC_W(PC_W), .NAR_W(NAR_W), .OFS_W(OFS_W)) u_rel (
        .base_pc (seq_pc),
        .offset  (operand[OFS_W-1:0]),
        .wide    (flat_mode),
        .rel_pc  (rel_pc)
    );

    pc_abs_form #(.PC_W(PC_W), .NAR_W(NAR_W), .WPAGE(WPAGE), .NPAGE(NPAGE)) u_abs (
        .base_pc (seq_pc),
        .field   (operand),
        .wide    (flat_mode),
        .long_pc (long_pc),
        .page_pc (page_pc)
    );

    always_comb begin
        state_d = state_q;
        if (!stall) begin
            state_d.pc = seq_pc;
            if (taken) begin
                unique case (kind)
                    JK_LONG: state_d.pc = long_pc;
                    JK_PAGE: state_d.pc = page_pc;
                    JK_REL:  state_d.pc = rel_pc;
                    default: state_d.pc = seq_pc;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc = state_q.pc;
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk (
    input logic        clk,
    input logic        rst,
    input logic        stall,
    input logic        flat_mode,
    input logic [2:0]  instr_len,
    input logic [1:0]  jump_kind,
    input logic        taken,
    input logic [23:0] operand,
    input logic [23:0] pc
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> pc == 24'd0);

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> pc == $past(pc));

    // R3
    narrow_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && !flat_mode && (jump_kind == 2'b00 || !taken))
        |=> pc[15:0] == 16'($past(pc[15:0]) + 16'($past(instr_len))));

    // R4
    wide_long_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && flat_mode && taken && jump_kind == 2'b01)
        |=> pc == $past(operand));

    // R5
    narrow_long_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && !flat_mode && taken && jump_kind == 2'b01)
        |=> pc == {8'h00, $past(operand[15:0])});

    // R6
    wide_page_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && flat_mode && taken && jump_kind == 2'b10)
        |=> pc[18:0] == $past(operand[18:0]));

    // R7
    narrow_page_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && !flat_mode && taken && jump_kind == 2'b10)
        |=> pc[10:0] == $past(operand[10:0]));

    // R10
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && !flat_mode) |=> pc[23:16] == 8'h00);
endmodule

bind pc_sequencer pc_sequencer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .flat_mode (flat_mode),
    .instr_len (instr_len),
    .jump_kind (jump_kind),
    .taken     (taken),
    .operand   (operand),
    .pc        (pc)
);

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic        flat_mode = 1'b0;
    logic [2:0]  instr_len = 3'd1;
    logic [1:0]  jump_kind = 2'b00;
    logic        taken = 1'b0;
    logic [23:0] operand = 24'd0;
    logic [23:0] pc;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int          due;
        logic [23:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t    sb_q[$];
    logic [23:0] model_pc = 24'd0;

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    pc_sequencer uut (
        .clk       (clk),
        .rst       (rst),
        .stall     (stall),
        .flat_mode (flat_mode),
        .instr_len (instr_len),
        .jump_kind (jump_kind),
        .taken     (taken),
        .operand   (operand),
        .pc        (pc)
    );

    // monitor: compares each expected value in the cycle it falls due
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (pc !== it.exp) begin
                n_errors++;
                $display("FAIL %s: pc=%06h expected=%06h", it.tag, pc, it.exp);
            end
        end
    end

    function automatic logic [23:0] predict(input logic [23:0] cur, input logic wide,
                                            input logic [2:0] len, input logic [1:0] kind,
                                            input logic tk, input logic [23:0] op);
        logic [23:0] m, follow, low;
        m      = wide ? 24'hFFFFFF : 24'h00FFFF;
        follow = (cur + {21'd0, len}) & m;
        low    = wide ? 24'h07FFFF : 24'h0007FF;
        if (!tk || kind == 2'b00) return follow;
        case (kind)
            2'b01:   return op & m;
            2'b10:   return (follow & m & ~low) | (op & low);
            default: return (follow + {{16{op[7]}}, op[7:0]}) & m;
        endcase
    endfunction

    task automatic drive(input logic wide, input logic [2:0] len, input logic [1:0] kind,
                         input logic tk, input logic [23:0] op, input logic hold, input string tag);
        @(negedge clk);
        rst       = 1'b0;
        flat_mode = wide;
        instr_len = len;
        jump_kind = kind;
        taken     = tk;
        operand   = op;
        stall     = hold;
        if (!hold) model_pc = predict(model_pc, wide, len, kind, tk, op);
        sb_q.push_back('{due: cyc + 1, exp: model_pc, tag: tag});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst      = 1'b1;
        operand  = 24'h55AA55;
        model_pc = 24'd0;
        sb_q.push_back('{due: cyc + 1, exp: 24'd0, tag: "R1 reset"});
    endtask

    initial begin
        do_reset();
        do_reset();
        drive(0, 3'd3, 2'b00, 0, 24'h0, 0, "R3 step 3");                 // 000003
        drive(0, 3'd3, 2'b01, 1, 24'hAB1234, 0, "R5 long narrow");       // 001234
        drive(0, 3'd5, 2'b00, 1, 24'hFFFFFF, 0, "R3 step 5");            // 001239
        drive(0, 3'd2, 2'b11, 0, 24'h000040, 0, "R3 branch not taken");  // 00123B
        drive(0, 3'd2, 2'b11, 1, 24'h000080, 0, "R9 offset -128");       // 0011BD
        drive(0, 3'd2, 2'b11, 1, 24'h00007F, 0, "R9 offset +127");       // 00123E
        drive(0, 3'd2, 2'b10, 1, 24'hFFF7FF, 0, "R7 page narrow");       // 0017FF
        drive(0, 3'd1, 2'b10, 1, 24'h000005, 0, "R8 page of next byte"); // 001805
        drive(0, 3'd4, 2'b01, 1, 24'h000000, 1, "R2 stall long");        // 001805
        drive(1, 3'd2, 2'b11, 1, 24'h000010, 1, "R2 stall rel");         // 001805
        drive(0, 3'd1, 2'b00, 0, 24'h0, 0, "R11 one-cycle step");         // 001806
        drive(0, 3'd3, 2'b01, 1, 24'h00FFFE, 0, "R5 long to top");       // 00FFFE
        drive(0, 3'd3, 2'b00, 0, 24'h0, 0, "R10 narrow wrap");            // 000001
        drive(0, 3'd2, 2'b11, 1, 24'h0000F0, 0, "R10 narrow rel wrap");  // 00FFF3
        drive(1, 3'd4, 2'b01, 1, 24'hABCDEF, 0, "R4 long wide");         // ABCDEF
        drive(1, 3'd2, 2'b10, 1, 24'h012345, 0, "R6 page wide");         // A92345
        drive(1, 3'd4, 2'b01, 1, 24'hA7FFFF, 0, "R4 long wide 2");       // A7FFFF
        drive(1, 3'd1, 2'b10, 1, 24'h000010, 0, "R8 wide page crossing"); // A80010
        drive(1, 3'd4, 2'b01, 1, 24'hFFFFFE, 0, "R4 long near top");     // FFFFFE
        drive(1, 3'd3, 2'b11, 1, 24'h000001, 0, "R10 wide wrap rel R9"); // 000002
        drive(1, 3'd4, 2'b01, 1, 24'h5A0010, 0, "R4 long upper bits");   // 5A0010
        drive(0, 3'd1, 2'b00, 0, 24'h0, 0, "R10 mode switch clears upper"); // 000011
        for (int i = 0; i < 300; i++) begin
            logic [2:0] len;
            len = 3'(1 + ($urandom % 5));
            drive(1'($urandom), len, 2'($urandom), 1'($urandom), 24'($urandom),
                  ($urandom % 8) == 0, "R11 random stream");
        end
        do_reset();
        drive(1, 3'd1, 2'b00, 0, 24'h0, 0, "R1 step after reset");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule